// File: doc/BRIEF.md
# Control-Port Register Map with Atomic Group Commit

This block is the register file behind a serial control port. A byte-level bus front end supplies start and stop strobes, a strobe for each received byte together with that byte, and a strobe for each byte it sends. The register file answers with the byte to send on a combinational output. After a start, the first received byte loads an internal address pointer. That pointer is write-only and is never returned by a read. Every later data byte, whether read or written, targets the pointed register and then moves the pointer on by one. This continues until the stop.

One configuration value, `GRP_W` bits wide, is split over consecutive registers starting at `GRP_BASE`. Its partial bytes are held in shadow storage. The live value changes in a single cycle, and only once the whole group has been written in ascending order with no other data access in between. A bank bit in a common register decides whether addresses from 0x40 upward reach the normal register space or an alternate space. That alternate space must end at or below 0x9C.

Top module: `ctlport_regfile`

## Requirements
- R1: A synchronous active-high reset clears every byte register to 0x00, clears the bank bit (normal space selected) and sets the group's live value to `GRP_RST`.
- R2: The first received byte after a start loads the pointer and changes no register. A transaction whose first access is a read returns the register at the pointer left by the previous transaction.
- R3: Each data byte read or written advances the pointer by one. Strobes outside a transaction (after a stop and before the next start) and strobes in the same cycle as a start or stop have no effect.
- R4: The group is laid out most significant byte first. Address `GRP_BASE` holds the top `GRP_W-8` bits in its low bits, with its unused upper bits read as 0. `GRP_BASE+1` holds bits 7:0. The live value and `grp_live` keep their old value until the final byte is written, and then all bits change together.
- R5: A write to a non-lowest group address that does not directly follow the write of the byte below it commits nothing.
- R6: Any other data access (a read, or a write to any other address) between the group writes discards the staged bytes. A later final-byte write then leaves the live value unchanged. A new sequence starts only with a write to `GRP_BASE`.
- R7: Reads of group addresses return the committed live value, never staged bytes.
- R8: The bank bit is bit 5 of register 0x0E. Addresses 0x00 to 0x3F reach the same registers whatever the bank bit holds.
- R9: With the bank bit 0, addresses from 0x40 reach the normal space. With it 1, they reach a separate alternate space. Each space keeps its own contents.
- R10: Writes to unimplemented addresses are ignored, and reads of them return 0x00. This covers gaps in the common range, beyond the normal space, and beyond the alternate space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start condition seen by the front end |
| bus_stop | input | 1 | Stop condition seen by the front end |
| wr_stb | input | 1 | A byte was received; `wr_data` is valid |
| rd_stb | input | 1 | The byte on `rd_data` has been sent |
| wr_data | input | 8 | Received byte |
| rd_data | output | 8 | Byte at the current pointer, for the next read |
| grp_live | output | GRP_W | Committed value of the multi-register group |

## Verification
The bench builds the block with a 12-bit group at 0x34, so two writes are needed for a commit. It uses 16 common registers, so addresses 0x10 to 0x33 are an unimplemented gap, and 16 normal upper registers. The alternate space is cut to 8 registers, so address 0x48 exists in the normal bank but not in the alternate one. A write ignored in one bank can therefore be seen to leave the other bank's byte intact. The group reset value 0xABC is non-zero, so the reset layout and the unchanged old value after a broken sequence can both be read back over the port.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;
   typedef logic [7:0] byte_t;
   localparam int UP_BASE   = 8'h40;
   localparam int ALT_LIMIT = 8'h9C;
endpackage

// File: rtl/ctlport_ptr.sv
module ctlport_ptr
   import ctlport_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  bus_start,
   input  logic  bus_stop,
   input  logic  wr_stb,
   input  logic  rd_stb,
   input  byte_t wr_data,
   output byte_t ptr,
   output logic  data_wr,
   output logic  data_rd
);
   logic  active_q, need_q, quiet, ptr_ld;
   byte_t ptr_q;

   assign quiet   = bus_start | bus_stop;
   assign ptr_ld  = active_q & ~quiet & wr_stb & need_q;
   assign data_wr = active_q & ~quiet & wr_stb & ~need_q;
   assign data_rd = active_q & ~quiet & rd_stb;
   assign ptr     = ptr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         need_q   <= 1'b0;
         ptr_q    <= '0;
      end else if (bus_start) begin
         active_q <= 1'b1;
         need_q   <= 1'b1;
      end else if (bus_stop) begin
         active_q <= 1'b0;
         need_q   <= 1'b0;
      end else if (ptr_ld) begin
         ptr_q  <= wr_data;
         need_q <= 1'b0;
      end else if (data_wr | data_rd) begin
         ptr_q  <= ptr_q + 8'd1;
         need_q <= 1'b0;
      end
   end
endmodule

// File: rtl/ctlport_stage.sv
module ctlport_stage
   import ctlport_pkg::*;
#(
   parameter int               GRP_BASE = 8'h34,
   parameter int               GRP_W    = 12,
   parameter logic [GRP_W-1:0] GRP_RST  = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic             rd_en,
   input  byte_t            addr,
   input  byte_t            wdata,
   output logic             hit,
   output byte_t            rbyte,
   output logic [GRP_W-1:0] live
);
   localparam int NB = (GRP_W + 7) / 8;
   localparam int PW = NB * 8;
   localparam int OW = (NB > 1) ? $clog2(NB) : 1;
   localparam int IW = $clog2(NB + 1);

   logic [GRP_W-1:0] live_q;
   logic [PW-1:0]    pad_live;
   logic [OW-1:0]    off;
   byte_t            lbytes [NB];

   assign hit      = (int'(addr) >= GRP_BASE) && (int'(addr) < GRP_BASE + NB);
   assign off      = OW'(addr - byte_t'(GRP_BASE));
   assign pad_live = PW'(live_q);
   assign live     = live_q;

   for (genvar k = 0; k < NB; k++) begin : g_lb
      assign lbytes[k] = pad_live[8*(NB-1-k) +: 8];
   end

   assign rbyte = hit ? lbytes[off] : 8'h00;

   if (NB == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (rst)                live_q <= GRP_RST;
         else if (wr_en && hit)  live_q <= GRP_W'(wdata);
      end
   end else begin : g_multi
      byte_t          stg [NB-1];
      logic [IW-1:0]  idx_q;
      logic [PW-1:0]  cmt;

      for (genvar k = 0; k < NB - 1; k++) begin : g_cm
         assign cmt[8*(NB-1-k) +: 8] = stg[k];
      end
      assign cmt[7:0] = wdata;

      always_ff @(posedge clk) begin
         if (rst) begin
            live_q <= GRP_RST;
            idx_q  <= '0;
            for (int k = 0; k < NB - 1; k++) stg[k] <= '0;
         end else if (wr_en && hit) begin
            if (int'(off) == 0) begin
               stg[0] <= wdata;
               idx_q  <= IW'(1);
            end else if (int'(off) == int'(idx_q)) begin
               if (int'(off) == NB - 1) begin
                  live_q <= GRP_W'(cmt);
                  idx_q  <= '0;
               end else begin
                  stg[off] <= wdata;
                  idx_q    <= idx_q + IW'(1);
               end
            end else begin
               idx_q <= '0;
            end
         end else if (wr_en || rd_en) begin
            idx_q <= '0;
         end
      end
   end
endmodule

// File: rtl/ctlport_store.sv
module ctlport_store
   import ctlport_pkg::*;
#(
   parameter int COM_REGS  = 16,
   parameter int NORM_REGS = 16,
   parameter int ALT_REGS  = 16,
   parameter int BANK_ADDR = 8'h0E,
   parameter int BANK_BIT  = 5
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  wr_en,
   input  byte_t addr,
   input  byte_t wdata,
   output byte_t rbyte,
   output logic  bank
);
   localparam int CW = $clog2(COM_REGS);
   localparam int NW = $clog2(NORM_REGS);

   byte_t         com_q  [COM_REGS];
   byte_t         norm_q [NORM_REGS];
   byte_t         up_off, alt_rd;
   logic          com_hit, in_up, norm_hit;
   logic [CW-1:0] ci;
   logic [NW-1:0] ni;

   assign up_off   = addr - byte_t'(UP_BASE);
   assign in_up    = int'(addr) >= UP_BASE;
   assign com_hit  = int'(addr) < COM_REGS;
   assign norm_hit = in_up && !bank && (int'(up_off) < NORM_REGS);
   assign ci       = addr[CW-1:0];
   assign ni       = up_off[NW-1:0];
   assign bank     = com_q[BANK_ADDR][BANK_BIT];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < COM_REGS; i++) com_q[i] <= '0;
      end else if (wr_en && com_hit) begin
         com_q[ci] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NORM_REGS; i++) norm_q[i] <= '0;
      end else if (wr_en && norm_hit) begin
         norm_q[ni] <= wdata;
      end
   end

   if (ALT_REGS > 0) begin : g_alt
      localparam int AW = (ALT_REGS > 1) ? $clog2(ALT_REGS) : 1;
      byte_t         alt_q [ALT_REGS];
      logic          alt_hit;
      logic [AW-1:0] ai;
      assign alt_hit = in_up && bank && (int'(up_off) < ALT_REGS);
      assign ai      = up_off[AW-1:0];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < ALT_REGS; i++) alt_q[i] <= '0;
         end else if (wr_en && alt_hit) begin
            alt_q[ai] <= wdata;
         end
      end
      assign alt_rd = alt_hit ? alt_q[ai] : 8'h00;
   end else begin : g_noalt
      assign alt_rd = 8'h00;
   end

   assign rbyte = com_hit  ? com_q[ci]  :
                  norm_hit ? norm_q[ni] : alt_rd;
endmodule

// File: rtl/ctlport_regfile.sv
module ctlport_regfile
   import ctlport_pkg::*;
#(
   parameter int               COM_REGS  = 16,
   parameter int               NORM_REGS = 16,
   parameter int               ALT_REGS  = 16,
   parameter int               BANK_ADDR = 8'h0E,
   parameter int               BANK_BIT  = 5,
   parameter int               GRP_BASE  = 8'h34,
   parameter int               GRP_W     = 12,
   parameter logic [GRP_W-1:0] GRP_RST   = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bus_start,
   input  logic             bus_stop,
   input  logic             wr_stb,
   input  logic             rd_stb,
   input  logic [7:0]       wr_data,
   output logic [7:0]       rd_data,
   output logic [GRP_W-1:0] grp_live
);
   localparam int NB = (GRP_W + 7) / 8;

   if (COM_REGS < 2 || COM_REGS > GRP_BASE) begin : g_bad_com
      $error("COM_REGS must lie between 2 and GRP_BASE");
   end
   if (GRP_BASE + NB > UP_BASE) begin : g_bad_grp
      $error("group must end below the banked range");
   end
   if (BANK_ADDR >= COM_REGS || BANK_BIT > 7) begin : g_bad_bank
      $error("bank bit must sit in an implemented common register");
   end
   if (NORM_REGS < 2 || UP_BASE + NORM_REGS > 256) begin : g_bad_norm
      $error("normal space size out of range");
   end
   if (ALT_REGS < 0 || UP_BASE + ALT_REGS > ALT_LIMIT + 1) begin : g_bad_alt
      $error("alternate space exceeds its limit");
   end

   byte_t ptr_w, grp_rb, sto_rb;
   logic  dwr, drd, grp_hit, bank_w;

   ctlport_ptr u_ptr (
      .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
      .wr_stb(wr_stb), .rd_stb(rd_stb), .wr_data(wr_data),
      .ptr(ptr_w), .data_wr(dwr), .data_rd(drd)
   );

   ctlport_stage #(.GRP_BASE(GRP_BASE), .GRP_W(GRP_W), .GRP_RST(GRP_RST)) u_stage (
      .clk(clk), .rst(rst), .wr_en(dwr), .rd_en(drd), .addr(ptr_w),
      .wdata(wr_data), .hit(grp_hit), .rbyte(grp_rb), .live(grp_live)
   );

   ctlport_store #(
      .COM_REGS(COM_REGS), .NORM_REGS(NORM_REGS), .ALT_REGS(ALT_REGS),
      .BANK_ADDR(BANK_ADDR), .BANK_BIT(BANK_BIT)
   ) u_store (
      .clk(clk), .rst(rst), .wr_en(dwr), .addr(ptr_w), .wdata(wr_data),
      .rbyte(sto_rb), .bank(bank_w)
   );

   assign rd_data = grp_hit ? grp_rb : sto_rb;
endmodule

// File: rtl/ctlport_chk.sv
module ctlport_chk #(
   parameter int               COM_REGS = 16,
   parameter int               GRP_BASE = 8'h34,
   parameter int               GRP_W    = 12,
   parameter logic [GRP_W-1:0] GRP_RST  = '0
) (
   input logic             clk,
   input logic             rst,
   input logic             bus_start,
   input logic             bus_stop,
   input logic [7:0]       ptr,
   input logic             data_wr,
   input logic             data_rd,
   input logic [7:0]       rd_data,
   input logic [GRP_W-1:0] grp_live
);
   localparam int NB   = (GRP_W + 7) / 8;
   localparam int LAST = GRP_BASE + NB - 1;

   p_reset_val_r1: assert property (@(posedge clk)
      rst |=> (grp_live == GRP_RST));

   p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
      (data_wr || data_rd) |=> (ptr == $past(ptr) + 8'd1));

   p_stop_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (bus_stop && !bus_start) |=> (ptr == $past(ptr)));

   p_live_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !(data_wr && int'(ptr) == LAST) |=> $stable(grp_live));

   p_gap_zero_r10: assert property (@(posedge clk) disable iff (rst)
      (int'(ptr) >= COM_REGS && int'(ptr) < GRP_BASE) |-> (rd_data == 8'h00));
endmodule

bind ctlport_regfile ctlport_chk #(
   .COM_REGS(COM_REGS), .GRP_BASE(GRP_BASE), .GRP_W(GRP_W), .GRP_RST(GRP_RST)
) u_chk (
   .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
   .ptr(ptr_w), .data_wr(dwr), .data_rd(drd), .rd_data(rd_data),
   .grp_live(grp_live)
);

// File: tb/sim_ctlport_regfile.sv
`timescale 1ns/1ps
module sim_ctlport_regfile;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_start = 1'b0, bus_stop = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic [7:0]  rd_data;
   logic [11:0] grp_live;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #2.5 clk = ~clk;

   ctlport_regfile #(
      .COM_REGS(16), .NORM_REGS(16), .ALT_REGS(8), .BANK_ADDR(8'h0E),
      .BANK_BIT(5), .GRP_BASE(8'h34), .GRP_W(12), .GRP_RST(12'hABC)
   ) u0 (
      .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
      .wr_stb(wr_stb), .rd_stb(rd_stb), .wr_data(wr_data),
      .rd_data(rd_data), .grp_live(grp_live)
   );

   // monitor: pops the scoreboard on every sent byte
   always @(negedge clk) begin
      if (!rst && rd_stb) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected read: got %h expected none", rd_data);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string      t = tag_q.pop_front();
            if (rd_data !== e) begin
               n_bad++;
               $display("FAIL %s: got %h expected %h", t, rd_data, e);
            end
         end
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask
   task automatic do_start();
      bus_start = 1'b1; tick(); bus_start = 1'b0;
   endtask
   task automatic do_stop();
      bus_stop = 1'b1; tick(); bus_stop = 1'b0;
   endtask
   task automatic wr(input logic [7:0] b);
      wr_data = b; wr_stb = 1'b1; tick(); wr_stb = 1'b0;
   endtask
   task automatic rd(input logic [7:0] e, input string t);
      exp_q.push_back(e); tag_q.push_back(t);
      rd_stb = 1'b1; tick(); rd_stb = 1'b0;
   endtask
   task automatic at(input logic [7:0] a);
      do_start(); wr(a);
   endtask
   task automatic chk_live(input logic [11:0] e, input string t);
      n_cmp++;
      if (grp_live !== e) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", t, grp_live, e);
      end
   endtask
   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
   end

   initial begin
      repeat (3) tick();
      rst = 1'b0; tick();
      // R1 reset state
      chk_live(12'hABC, "R1");
      at(8'h00); rd(8'h00, "R1"); rd(8'h00, "R1"); do_stop();
      at(8'h34); rd(8'h0A, "R1"); rd(8'hBC, "R1"); do_stop();
      at(8'h0E); rd(8'h00, "R1"); do_stop();
      // R2 / R3 pointer load and auto-increment
      at(8'h03); wr(8'h11); wr(8'h22); wr(8'h33); do_stop();
      at(8'h03); rd(8'h11, "R3"); rd(8'h22, "R3"); rd(8'h33, "R3"); do_stop();
      wr(8'h77);                        // outside a transaction: ignored
      at(8'h06); rd(8'h00, "R3"); do_stop();
      at(8'h03); do_stop();
      do_start(); rd(8'h11, "R2"); rd(8'h22, "R2"); do_stop();
      // R4 atomic commit
      at(8'h34); wr(8'h05);
      chk_live(12'hABC, "R4");
      wr(8'h67);
      chk_live(12'h567, "R4");
      do_stop();
      at(8'h34); rd(8'h05, "R4"); rd(8'h67, "R4"); do_stop();
      // R7 read during staging returns live
      at(8'h34); wr(8'h09); do_stop();
      chk_live(12'h567, "R7");
      at(8'h34); rd(8'h05, "R7"); do_stop();
      // R6 interleaved write breaks the sequence
      at(8'h34); wr(8'h0C); do_stop();
      at(8'h10); wr(8'h99); do_stop();
      at(8'h35); wr(8'hDE); do_stop();
      chk_live(12'h567, "R6");
      // R6 interleaved read breaks the sequence
      at(8'h34); wr(8'h0C); do_stop();
      at(8'h03); rd(8'h11, "R6"); do_stop();
      at(8'h35); wr(8'hDE); do_stop();
      chk_live(12'h567, "R6");
      // R5 final byte without lowest byte first
      at(8'h35); wr(8'h44); do_stop();
      chk_live(12'h567, "R5");
      at(8'h35); wr(8'h44); wr(8'h00); do_stop();
      chk_live(12'h567, "R5");
      // R4 second commit, upper bits of low address
      at(8'h34); wr(8'hF1); wr(8'h23); do_stop();
      chk_live(12'h123, "R4");
      at(8'h34); rd(8'h01, "R4"); do_stop();
      // R10 gap in common range
      at(8'h20); wr(8'h55); do_stop();
      at(8'h20); rd(8'h00, "R10"); do_stop();
      // R9 normal bank writes
      at(8'h40); wr(8'hA1); wr(8'hA2); do_stop();
      at(8'h48); wr(8'h5A); do_stop();
      at(8'h50); wr(8'h3C); rd(8'h00, "R10"); do_stop();
      at(8'h50); rd(8'h00, "R10"); do_stop();
      // R8 select alternate bank
      at(8'h0E); wr(8'h20); do_stop();
      at(8'h0E); rd(8'h20, "R8"); do_stop();
      at(8'h03); rd(8'h11, "R8"); do_stop();
      at(8'h34); rd(8'h01, "R8"); do_stop();
      at(8'h40); rd(8'h00, "R9"); rd(8'h00, "R9"); do_stop();
      at(8'h40); wr(8'hB1); do_stop();
      at(8'h48); wr(8'h66); do_stop();
      at(8'h48); rd(8'h00, "R10"); do_stop();
      at(8'h40); rd(8'hB1, "R9"); do_stop();
      // back to normal bank
      at(8'h0E); wr(8'h00); do_stop();
      at(8'h40); rd(8'hA1, "R9"); rd(8'hA2, "R9"); do_stop();
      at(8'h48); rd(8'h5A, "R10"); do_stop();
      at(8'h03); rd(8'h11, "R8"); do_stop();
      tick(); tick();
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL scoreboard: got %0d left expected 0", exp_q.size());
      end
      finish_run();
   end
endmodule